// File: doc/BRIEF.md
# Vector register lane unit

The block combines a file of vector registers with a function unit that works through one element per cycle. A single command names an operation, a destination register, one or two source registers and a scalar. The unit then walks the element index from zero to the last element on its own, so no per-element loop, branch or index update is needed outside the block. The operations are elementwise vector addition, adding one scalar to every element, multiplying every element by one scalar, filling a register from an incoming element stream, and sending a register out as an element stream. Arithmetic is two's-complement integer arithmetic that wraps at the element width.

A command is taken only while the unit is idle. From the next cycle a busy flag stays high until the last element has been handled. A one-cycle done pulse then marks the end. The load and store streams each use a valid/ready pair, so the outside memory may stall either stream at any element. Because each element is read in the same cycle in which it is written, the destination may be the same register as a source.

Top module: `vlu_top`

## Requirements
- R1: After reset, busy, done, ld_ready and st_valid are all low.
- R2: Opcode 0 (vector add) writes vd[i] = vs1[i] + vs2[i], truncated to DATA_W bits, for every element i.
- R3: Opcode 1 (scalar add) writes vd[i] = vs1[i] + scalar, truncated to DATA_W bits.
- R4: Opcode 2 (scalar multiply) writes vd[i] = the low DATA_W bits of vs1[i] * scalar.
- R5: Opcode 3 (load) holds ld_ready high while it runs. Each cycle with ld_valid and ld_ready both high writes ld_data into element i of vd, with i running from 0 upward. A cycle with ld_valid low writes nothing and does not advance i.
- R6: Opcode 4 (store) holds st_valid high and presents st_data = vs1[i], with i running from 0 upward. i advances only in a cycle where st_ready is high. While st_ready is low, st_data holds its value.
- R7: An arithmetic command accepted at a clock edge keeps busy high for exactly NUM_ELEMS cycles, starting in the next cycle. In the cycle after the last element, busy is low and done is high for exactly one cycle.
- R8: A command presented while busy is high is ignored: it alters no register and does not change the running command.
- R9: When vd equals a source register, every element of the result is computed from the old value of that element.
- R10: Opcodes 5 to 7 are ignored: busy and done stay low, and no stream handshake starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 3 | Operation code (0 vadd, 1 scalar add, 2 scalar mul, 3 load, 4 store) |
| cmd_vd | input | $clog2(NUM_REGS) | Destination register index |
| cmd_vs1 | input | $clog2(NUM_REGS) | First source register index (also the store source) |
| cmd_vs2 | input | $clog2(NUM_REGS) | Second source register index |
| cmd_scalar | input | DATA_W | Scalar operand |
| ld_valid | input | 1 | Load element present |
| ld_data | input | DATA_W | Load element value |
| ld_ready | output | 1 | Unit takes a load element |
| st_valid | output | 1 | Store element present |
| st_ready | input | 1 | Receiver takes the store element |
| st_data | output | DATA_W | Store element value |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse after the last element |

## Verification
The bench builds the block with NUM_REGS = 4, NUM_ELEMS = 8 and DATA_W = 16. The short registers make the exact busy length and the done pulse quick to count, and each register can be checked element by element through a store. With 16-bit elements, wrapping sums and truncated products come up often with ordinary operand values. Stalls on both streams, commands that arrive while busy, undefined opcodes and in-place operations on an aliased register are all driven directly.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

  typedef enum logic [2:0] {
    OP_VADD   = 3'd0,
    OP_VADDS  = 3'd1,
    OP_VMULS  = 3'd2,
    OP_VLOAD  = 3'd3,
    OP_VSTORE = 3'd4
  } vlu_op_e;

  function automatic logic op_known(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_arith(input vlu_op_e op);
    return (op == OP_VADD) || (op == OP_VADDS) || (op == OP_VMULS);
  endfunction

endpackage

// File: rtl/vlu_regfile.sv
module vlu_regfile #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_ELEMS = 64,
  parameter int DATA_W    = 64,
  localparam int RW = $clog2(NUM_REGS),
  localparam int EW = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_reg,
  input  logic [EW-1:0]     wr_elem,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [EW-1:0]     rd_elem,
  input  logic [RW-1:0]     rd_reg_a,
  input  logic [RW-1:0]     rd_reg_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);

  logic [DATA_W-1:0] mem [NUM_REGS][NUM_ELEMS];

  // Reads are combinational so the element being written is read first.
  assign rd_data_a = mem[rd_reg_a][rd_elem];
  assign rd_data_b = mem[rd_reg_b][rd_elem];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_reg][wr_elem] <= wr_data;
  end

endmodule

// File: rtl/vlu_alu.sv
module vlu_alu
  import vlu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  vlu_op_e           op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] scalar,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] result
);

  function automatic logic [DATA_W-1:0] lane_calc(
    input vlu_op_e           f_op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] s,
    input logic [DATA_W-1:0] ld
  );
    logic [DATA_W-1:0] r;
    case (f_op)
      OP_VADD:  r = a + b;
      OP_VADDS: r = a + s;
      OP_VMULS: r = a * s;
      OP_VLOAD: r = ld;
      default:  r = '0;
    endcase
    return r;
  endfunction

  assign result = lane_calc(op, src_a, src_b, scalar, ld_data);

endmodule

// File: rtl/vlu_seq.sv
module vlu_seq
  import vlu_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int NUM_ELEMS = 64,
  parameter int DATA_W    = 64,
  localparam int RW = $clog2(NUM_REGS),
  localparam int EW = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [RW-1:0]     cmd_vd,
  input  logic [RW-1:0]     cmd_vs1,
  input  logic [RW-1:0]     cmd_vs2,
  input  logic [DATA_W-1:0] cmd_scalar,
  input  logic              ld_valid,
  input  logic              st_ready,
  output logic              busy,
  output logic              done,
  output logic              ld_ready,
  output logic              st_valid,
  output logic              wr_en,
  output vlu_op_e           cur_op,
  output logic [RW-1:0]     cur_vd,
  output logic [RW-1:0]     cur_vs1,
  output logic [RW-1:0]     cur_vs2,
  output logic [DATA_W-1:0] cur_scalar,
  output logic [EW-1:0]     elem_idx
);

  localparam logic [EW-1:0] LAST_IDX = EW'(NUM_ELEMS - 1);

  logic accept;
  logic step;
  logic last_elem;

  assign accept    = cmd_valid && !busy && op_known(cmd_op);
  assign ld_ready  = busy && (cur_op == OP_VLOAD);
  assign st_valid  = busy && (cur_op == OP_VSTORE);
  assign last_elem = (elem_idx == LAST_IDX);

  always_comb begin
    step = 1'b0;
    if (busy) begin
      if (op_is_arith(cur_op))        step = 1'b1;
      else if (cur_op == OP_VLOAD)    step = ld_valid;
      else if (cur_op == OP_VSTORE)   step = st_ready;
    end
  end

  assign wr_en = step && (cur_op != OP_VSTORE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      elem_idx   <= '0;
      cur_op     <= OP_VADD;
      cur_vd     <= '0;
      cur_vs1    <= '0;
      cur_vs2    <= '0;
      cur_scalar <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy       <= 1'b1;
        elem_idx   <= '0;
        cur_op     <= vlu_op_e'(cmd_op);
        cur_vd     <= cmd_vd;
        cur_vs1    <= cmd_vs1;
        cur_vs2    <= cmd_vs2;
        cur_scalar <= cmd_scalar;
      end else if (step) begin
        if (last_elem) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          elem_idx <= '0;
        end else begin
          elem_idx <= elem_idx + 1'b1;
        end
      end
    end
  end

  // Checker counter: elements handled by the current command.
  logic [EW:0] chk_steps;
  always_ff @(posedge clk) begin
    if (!rst_n)      chk_steps <= '0;
    else if (accept) chk_steps <= '0;
    else if (step)   chk_steps <= chk_steps + 1'b1;
  end

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_from_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  assert_full_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_steps == (EW+1)'(NUM_ELEMS)));

  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(cur_op) && $stable(cur_vd) && $stable(cur_vs1)));

  assert_unknown_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_op > 3'd4)) |=> !busy);

endmodule

// File: rtl/vlu_top.sv
module vlu_top
  import vlu_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int NUM_ELEMS = 64,
  parameter int DATA_W    = 64,
  localparam int RW = $clog2(NUM_REGS),
  localparam int EW = $clog2(NUM_ELEMS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [RW-1:0]     cmd_vd,
  input  logic [RW-1:0]     cmd_vs1,
  input  logic [RW-1:0]     cmd_vs2,
  input  logic [DATA_W-1:0] cmd_scalar,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [DATA_W-1:0] st_data,
  output logic              busy,
  output logic              done
);

  vlu_op_e           cur_op;
  logic [RW-1:0]     cur_vd, cur_vs1, cur_vs2;
  logic [DATA_W-1:0] cur_scalar;
  logic [EW-1:0]     elem_idx;
  logic              wr_en;
  logic [DATA_W-1:0] rd_a, rd_b, lane_result;

  vlu_seq #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS), .DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_vd     (cmd_vd),
    .cmd_vs1    (cmd_vs1),
    .cmd_vs2    (cmd_vs2),
    .cmd_scalar (cmd_scalar),
    .ld_valid   (ld_valid),
    .st_ready   (st_ready),
    .busy       (busy),
    .done       (done),
    .ld_ready   (ld_ready),
    .st_valid   (st_valid),
    .wr_en      (wr_en),
    .cur_op     (cur_op),
    .cur_vd     (cur_vd),
    .cur_vs1    (cur_vs1),
    .cur_vs2    (cur_vs2),
    .cur_scalar (cur_scalar),
    .elem_idx   (elem_idx)
  );

  vlu_regfile #(.NUM_REGS(NUM_REGS), .NUM_ELEMS(NUM_ELEMS), .DATA_W(DATA_W)) u_rf (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_reg    (cur_vd),
    .wr_elem   (elem_idx),
    .wr_data   (lane_result),
    .rd_elem   (elem_idx),
    .rd_reg_a  (cur_vs1),
    .rd_reg_b  (cur_vs2),
    .rd_data_a (rd_a),
    .rd_data_b (rd_b)
  );

  vlu_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (cur_op),
    .src_a   (rd_a),
    .src_b   (rd_b),
    .scalar  (cur_scalar),
    .ld_data (ld_data),
    .result  (lane_result)
  );

  assign st_data = rd_a;

  assert_ldready_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (busy && !st_valid));

  assert_store_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

endmodule

// File: tb/vlu_top_tb.sv
module vlu_top_tb;

  localparam int NR = 4;
  localparam int NE = 8;
  localparam int W  = 16;
  localparam int RW = $clog2(NR);

  localparam logic [2:0] C_VADD = 3'd0, C_VADDS = 3'd1, C_VMULS = 3'd2,
                         C_VLOAD = 3'd3, C_VSTORE = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [RW-1:0] cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
  logic [W-1:0]  cmd_scalar = '0;
  logic          ld_valid = 1'b0;
  logic [W-1:0]  ld_data = '0;
  logic          ld_ready, st_valid, busy, done;
  logic          st_ready = 1'b0;
  logic [W-1:0]  st_data;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] mdl [NR][NE];

  always #5 clk = ~clk;

  vlu_top #(.NUM_REGS(NR), .NUM_ELEMS(NE), .DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2), .cmd_scalar(cmd_scalar),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_ready(ld_ready),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int vd, input int vs1,
                       input int vs2, input logic [W-1:0] sc);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    cmd_vd = RW'(vd); cmd_vs1 = RW'(vs1); cmd_vs2 = RW'(vs2); cmd_scalar = sc;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic load_reg(input int r, input bit gaps);
    issue(C_VLOAD, r, 0, 0, '0);
    for (int i = 0; i < NE; i++) begin
      logic [W-1:0] v;
      v = W'(i * 16'h1357 + r * 16'h2468 + 16'hF00F);
      if (gaps && (i % 3 == 1)) begin
        ld_valid = 1'b0;
        @(negedge clk);
        chk("R5 ready held during gap", {63'd0, ld_ready}, 64'd1);
      end
      ld_valid = 1'b1; ld_data = v;
      if (i == 0) chk("R5 ld_ready", {63'd0, ld_ready}, 64'd1);
      mdl[r][i] = v;
      @(negedge clk);
    end
    ld_valid = 1'b0;
    chk("R5 load done", {62'd0, done, busy}, 64'd2);
  endtask

  task automatic store_check(input int r, input bit stall, input string req);
    issue(C_VSTORE, 0, r, 0, '0);
    for (int i = 0; i < NE; i++) begin
      if (stall && (i % 2 == 0)) begin
        logic [W-1:0] held;
        st_ready = 1'b0;
        held = st_data;
        @(negedge clk);
        chk("R6 data held in stall", {48'd0, st_data}, {48'd0, held});
      end
      st_ready = 1'b1;
      chk({req, " st_valid"}, {63'd0, st_valid}, 64'd1);
      chk({req, " element"}, {48'd0, st_data}, {48'd0, mdl[r][i]});
      @(negedge clk);
    end
    st_ready = 1'b0;
    chk("R6 store done", {62'd0, done, busy}, 64'd2);
  endtask

  task automatic arith(input logic [2:0] op, input int vd, input int vs1,
                       input int vs2, input logic [W-1:0] sc, input string req);
    logic [W-1:0] nxt [NE];
    int cnt;
    for (int i = 0; i < NE; i++) begin
      logic [31:0] wide;
      case (op)
        C_VADD:  wide = {16'd0, mdl[vs1][i]} + {16'd0, mdl[vs2][i]};
        C_VADDS: wide = {16'd0, mdl[vs1][i]} + {16'd0, sc};
        default: wide = {16'd0, mdl[vs1][i]} * {16'd0, sc};
      endcase
      nxt[i] = wide[15:0];
    end
    issue(op, vd, vs1, vs2, sc);
    cnt = 0;
    while (busy && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R7 busy length", 64'(cnt), 64'(NE));
    chk("R7 done pulse", {63'd0, done}, 64'd1);
    @(negedge clk);
    chk("R7 done one cycle", {63'd0, done}, 64'd0);
    for (int i = 0; i < NE; i++) mdl[vd][i] = nxt[i];
    store_check(vd, 1'b0, req);
  endtask

  task automatic busy_ignore;
    // Start scalar add into r3, then offer a vector add into r2 mid-run.
    issue(C_VADDS, 3, 0, 0, 16'h0101);
    for (int i = 0; i < NE; i++) mdl[3][i] = mdl[0][i] + 16'h0101;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_VADD; cmd_vd = 2'd2; cmd_vs1 = 2'd0; cmd_vs2 = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy) @(negedge clk);
    chk("R8 first command done", {63'd0, done}, 64'd1);
    @(negedge clk);
    chk("R8 no second command", {63'd0, busy}, 64'd0);
    store_check(2, 1'b0, "R8 ignored target unchanged");
    store_check(3, 1'b0, "R8 running command result");
  endtask

  task automatic unknown_ops;
    for (int c = 5; c < 8; c++) begin
      issue(3'(c), 1, 1, 1, 16'h7);
      chk("R10 busy stays low", {63'd0, busy}, 64'd0);
      @(negedge clk);
      chk("R10 no done/handshake", {61'd0, done, ld_ready, st_valid}, 64'd0);
    end
    store_check(1, 1'b0, "R10 register unchanged");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {60'd0, busy, done, ld_ready, st_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {60'd0, busy, done, ld_ready, st_valid}, 64'd0);

    load_reg(0, 1'b0);
    load_reg(1, 1'b1);
    load_reg(2, 1'b0);
    store_check(1, 1'b1, "R6 stalled store");
    store_check(0, 1'b0, "R5 loaded contents");

    arith(C_VADD,  3, 0, 1, '0,       "R2 vector add");
    arith(C_VADDS, 2, 0, 0, 16'hFFF0, "R3 scalar add wrap");
    arith(C_VMULS, 3, 1, 0, 16'h0123, "R4 scalar mul low bits");
    arith(C_VADD,  0, 0, 0, '0,       "R9 alias vd=vs1=vs2");
    arith(C_VMULS, 1, 1, 0, 16'h0003, "R9 alias mul in place");
    arith(C_VADD,  2, 1, 2, '0,       "R9 alias vd=vs2");

    busy_ignore();
    unknown_ops();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule